// File: doc/BRIEF.md
# Transfer Byte Counter with Address Tracker

This block keeps track of a byte-serial data transfer. It holds a 24-bit count of bytes still to move, which counts down, and a 32-bit committed address, which counts up. Both move together, and only when the transfer logic confirms that a byte has safely crossed the bus (`xfer_ack`). A second, speculative address counts up on read-ahead requests (`xfer_prefetch`). It may run ahead of the committed one. Only the committed address is guaranteed to name the byte after the last one transferred.

Software reaches the block through a byte-wide register port. Writes take effect at the clock edge and reads are combinational from `reg_addr`. Multi-byte values are little-endian at consecutive offsets. Two sticky status flags report the count reaching zero (done) and the count wrapping below zero (wrap). Each flag has an enable that gates it onto `irq`. The handshake strobes are plain single-cycle pulses, one per byte, with no back-pressure, because the block has no data path of its own.

Register offsets: 0..2 count; 3 control; 4..7 committed address; 8..11 speculative address; 12 status; 13 interrupt enable. Any other offset reads 0.

Top module: `xfer_tally`

## Requirements
- R1: After reset, the count, both addresses, the status flags and the enables are 0, and `irq` is low.
- R2: A write to offset 0, 1 or 2 replaces byte 0, 1 or 2 of the count (little-endian). Reads return the stored value. Loading the count never sets the done flag.
- R3: Each `xfer_ack` cycle lowers the count by exactly one. `xfer_prefetch` leaves the count unchanged.
- R4: An `xfer_ack` that moves the count from 1 to 0 sets the done flag, status bit 0.
- R5: The committed address at offsets 4..7 (little-endian) rises by one on each `xfer_ack` that lowers the count, with carry across bytes. It does not move on `xfer_prefetch`.
- R6: An `xfer_ack` while the count is 0 sets the count to 0xFFFFFF and sets the wrap flag, status bit 1. It does not set the done flag.
- R7: A write to offset 3 with bit 0 set clears the count to 0 without setting the done flag. A write there with bit 0 clear has no effect.
- R8: Status at offset 12 is write-1-to-clear: a 1 clears that flag and a 0 leaves it. If a flag is set and cleared in the same cycle, the set wins.
- R9: Offset 13 holds the enables: bit 0 for done, bit 1 for wrap. `irq` is high when any flag is set together with its enable.
- R10: The speculative address at offsets 8..11 rises by one on each `xfer_prefetch`. A write to committed-address byte k loads byte k of both addresses. Writes to offsets 8..11 are ignored.
- R11: An `xfer_ack` in the same cycle as a write to the count, a clearing control write or a committed-address write is dropped. The write takes effect; the count, the committed address and the flags are not otherwise changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data at `reg_addr`, combinational |
| xfer_ack | input | 1 | One byte confirmed transferred |
| xfer_prefetch | input | 1 | One byte requested ahead |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
Two collisions are provoked by raising `xfer_ack` in the same cycle as a register write. In the first, the count sits at zero and the wrap flag is cleared with write-1 during the wrapping acknowledge. The flag must read back set, and the count must read 0xFFFFFF. In the second, a single count byte is written during an acknowledge. The written byte must replace only its own lane, and the committed address must read back unmoved.

// File: rtl/xfer_tally_pkg.sv
package xfer_tally_pkg;
  localparam int BYTE_W       = 8;
  localparam int NUM_FLAGS    = 2;
  localparam int FLAG_DONE    = 0;
  localparam int FLAG_WRAP    = 1;
  localparam int CTRL_CLR_BIT = 0;
endpackage

// File: rtl/xt_down_counter.sv
module xt_down_counter #(
  parameter int W  = 24,
  parameter int BW = 8,
  localparam int NB = W / BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] byte_we,
  input  logic [BW-1:0] wdata,
  input  logic          clr,
  input  logic          step,
  output logic [W-1:0]  cnt,
  output logic          reach_zero,
  output logic          wrap
);
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (clr) begin
      cnt_n = '0;
    end else if (|byte_we) begin
      for (int b = 0; b < NB; b++) begin
        if (byte_we[b]) cnt_n[b*BW +: BW] = wdata;
      end
    end else if (step) begin
      cnt_n = cnt - W'(1);
    end
  end

  // step arrives already qualified by the top; events follow the count value
  assign reach_zero = step && (cnt == W'(1));
  assign wrap       = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/xt_up_address.sv
module xt_up_address #(
  parameter int W  = 32,
  parameter int BW = 8,
  localparam int NB = W / BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] byte_we,
  input  logic [BW-1:0] wdata,
  input  logic          step,
  output logic [W-1:0]  addr
);
  logic [W-1:0] addr_n;

  always_comb begin
    addr_n = addr;
    if (|byte_we) begin
      for (int b = 0; b < NB; b++) begin
        if (byte_we[b]) addr_n[b*BW +: BW] = wdata;
      end
    end else if (step) begin
      addr_n = addr + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_n;
  end
endmodule

// File: rtl/xt_status_irq.sv
module xt_status_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] w1c,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~w1c) | set;  // a fresh event outranks its clear
      if (en_we) enable <= en_wdata;
    end
  end

  assign irq = |(status & enable);
endmodule

// File: rtl/xfer_tally.sv
module xfer_tally
  import xfer_tally_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              xfer_ack,
  input  logic              xfer_prefetch,
  output logic              irq
);
  localparam int CNT_NB   = CNT_W / BYTE_W;
  localparam int ADR_NB   = ADDR_W / BYTE_W;
  localparam int OFS_CNT  = 0;
  localparam int OFS_CTRL = OFS_CNT + CNT_NB;
  localparam int OFS_CADR = OFS_CTRL + 1;
  localparam int OFS_SADR = OFS_CADR + ADR_NB;
  localparam int OFS_STAT = OFS_SADR + ADR_NB;
  localparam int OFS_EN   = OFS_STAT + 1;

  logic [CNT_NB-1:0]    cnt_we;
  logic [ADR_NB-1:0]    adr_we;
  logic                 clr_hit, ack_eff, pf_eff, en_we;
  logic [NUM_FLAGS-1:0] stat_w1c, flag_set, status_q, enable_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [ADDR_W-1:0]    caddr_q, saddr_q;
  logic                 ev_zero, ev_wrap;

  for (genvar b = 0; b < CNT_NB; b++) begin : g_cnt_dec
    assign cnt_we[b] = reg_wr && (reg_addr == RA_W'(OFS_CNT + b));
  end
  for (genvar b = 0; b < ADR_NB; b++) begin : g_adr_dec
    assign adr_we[b] = reg_wr && (reg_addr == RA_W'(OFS_CADR + b));
  end

  assign clr_hit  = reg_wr && (reg_addr == RA_W'(OFS_CTRL)) && reg_wdata[CTRL_CLR_BIT];
  assign en_we    = reg_wr && (reg_addr == RA_W'(OFS_EN));
  assign stat_w1c = (reg_wr && (reg_addr == RA_W'(OFS_STAT))) ? reg_wdata[NUM_FLAGS-1:0] : '0;

  // host writes to the tracked state take priority over a coincident strobe
  assign ack_eff = xfer_ack && !(|cnt_we) && !clr_hit && !(|adr_we);
  assign pf_eff  = xfer_prefetch && !(|adr_we);

  xt_down_counter #(.W(CNT_W), .BW(BYTE_W)) u_count (
    .clk(clk), .rst_n(rst_n), .byte_we(cnt_we), .wdata(reg_wdata),
    .clr(clr_hit), .step(ack_eff), .cnt(cnt_q),
    .reach_zero(ev_zero), .wrap(ev_wrap)
  );

  xt_up_address #(.W(ADDR_W), .BW(BYTE_W)) u_commit_addr (
    .clk(clk), .rst_n(rst_n), .byte_we(adr_we), .wdata(reg_wdata),
    .step(ack_eff), .addr(caddr_q)
  );

  xt_up_address #(.W(ADDR_W), .BW(BYTE_W)) u_spec_addr (
    .clk(clk), .rst_n(rst_n), .byte_we(adr_we), .wdata(reg_wdata),
    .step(pf_eff), .addr(saddr_q)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_DONE] = ev_zero;
    flag_set[FLAG_WRAP] = ev_wrap;
  end

  xt_status_irq #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .w1c(stat_w1c),
    .en_we(en_we), .en_wdata(reg_wdata[NUM_FLAGS-1:0]),
    .status(status_q), .enable(enable_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < CNT_NB; b++)
      if (reg_addr == RA_W'(OFS_CNT + b)) reg_rdata = cnt_q[b*BYTE_W +: BYTE_W];
    for (int b = 0; b < ADR_NB; b++) begin
      if (reg_addr == RA_W'(OFS_CADR + b)) reg_rdata = caddr_q[b*BYTE_W +: BYTE_W];
      if (reg_addr == RA_W'(OFS_SADR + b)) reg_rdata = saddr_q[b*BYTE_W +: BYTE_W];
    end
    if (reg_addr == RA_W'(OFS_STAT)) reg_rdata = BYTE_W'(status_q);
    if (reg_addr == RA_W'(OFS_EN))   reg_rdata = BYTE_W'(enable_q);
  end
endmodule

// File: rtl/xfer_tally_chk.sv
module xfer_tally_chk #(
  parameter int CW     = 24,
  parameter int AW     = 32,
  parameter int RA_W   = 4,
  parameter int CTRL_A = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [RA_W-1:0] reg_addr,
  input logic            reg_wr,
  input logic [7:0]      reg_wdata,
  input logic            xfer_ack,
  input logic            xfer_prefetch,
  input logic [CW-1:0]   cnt,
  input logic [AW-1:0]   caddr,
  input logic [AW-1:0]   saddr,
  input logic [1:0]      status
);
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !reg_wr) |=> (cnt == $past(cnt) - CW'(1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ack && !reg_wr) |=> $stable(cnt));

  a_r5_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !reg_wr) |=> (caddr == $past(caddr) + AW'(1)));

  a_r4_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !reg_wr && cnt == CW'(1)) |=> status[0]);

  a_r6_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !reg_wr && cnt == '0) |=> (status[1] && cnt == '1));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_W'(CTRL_A) && reg_wdata[0]) |=> (cnt == '0));

  a_r10_spec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_prefetch && !reg_wr) |=> $stable(saddr));
endmodule

bind xfer_tally xfer_tally_chk #(
  .CW(CNT_W), .AW(ADDR_W), .RA_W(RA_W), .CTRL_A(OFS_CTRL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .xfer_ack(xfer_ack), .xfer_prefetch(xfer_prefetch),
  .cnt(cnt_q), .caddr(caddr_q), .saddr(saddr_q), .status(status_q)
);

// File: tb/xfer_tally_tb_top.sv
`timescale 1ns/100ps
module xfer_tally_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       xfer_ack = 1'b0;
  logic       xfer_prefetch = 1'b0;
  logic       irq;

  always #2.5 clk = ~clk;

  xfer_tally dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_ack(xfer_ack),
    .xfer_prefetch(xfer_prefetch), .irq(irq)
  );

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  event  sample_ev;
  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;

  // monitor: pops each expected item and compares it with the live outputs
  initial begin
    forever begin
      item_t it;
      logic [7:0] act;
      @(sample_ev);
      while (exp_q.size() > 0) begin
        it  = exp_q.pop_front();
        act = it.is_irq ? {7'd0, irq} : reg_rdata;
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    reg_addr = a;
    #1;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    exp_q.push_back(it);
    -> sample_ev;
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_ack(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; xfer_ack = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; xfer_ack = 1'b0;
  endtask

  task automatic ack(input int n);
    @(negedge clk);
    xfer_ack = 1'b1;
    repeat (n) @(negedge clk);
    xfer_ack = 1'b0;
  endtask

  task automatic prefetch(input int n);
    @(negedge clk);
    xfer_prefetch = 1'b1;
    repeat (n) @(negedge clk);
    xfer_prefetch = 1'b0;
  endtask

  initial begin
    #50000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reg(4'd0, 8'h00, "R1 count byte0");
    chk_reg(4'd4, 8'h00, "R1 committed addr byte0");
    chk_reg(4'd8, 8'h00, "R1 spec addr byte0");
    chk_reg(4'd12, 8'h00, "R1 status");
    chk_reg(4'd13, 8'h00, "R1 enable");
    chk_irq(1'b0, "R1 irq");

    wr(4'd0, 8'h03); wr(4'd1, 8'h00); wr(4'd2, 8'h00);
    chk_reg(4'd0, 8'h03, "R2 count load byte0");
    chk_reg(4'd12, 8'h00, "R2 load leaves done clear");
    wr(4'd4, 8'hFE); wr(4'd5, 8'h00); wr(4'd6, 8'h00); wr(4'd7, 8'h10);
    chk_reg(4'd7, 8'h10, "R5 committed addr byte3");
    chk_reg(4'd8, 8'hFE, "R10 spec addr follows committed load");
    wr(4'd13, 8'h01);

    ack(2);
    chk_reg(4'd0, 8'h01, "R3 count after two acks");
    chk_reg(4'd4, 8'h00, "R5 addr byte0 carry");
    chk_reg(4'd5, 8'h01, "R5 addr byte1 carry");
    chk_irq(1'b0, "R9 irq low before done");

    prefetch(3);
    chk_reg(4'd0, 8'h01, "R3 prefetch leaves count");
    chk_reg(4'd4, 8'h00, "R5 prefetch leaves committed addr");
    chk_reg(4'd8, 8'h01, "R10 spec addr byte0");
    chk_reg(4'd9, 8'h01, "R10 spec addr byte1");

    ack(1);
    chk_reg(4'd0, 8'h00, "R4 count reached zero");
    chk_reg(4'd12, 8'h01, "R4 done set");
    chk_irq(1'b1, "R9 irq on enabled done");
    chk_reg(4'd4, 8'h01, "R5 addr after third ack");

    wr(4'd12, 8'h00);
    chk_reg(4'd12, 8'h01, "R8 write zero keeps flag");
    wr(4'd12, 8'h01);
    chk_reg(4'd12, 8'h00, "R8 write one clears flag");
    chk_irq(1'b0, "R9 irq drops after clear");

    ack(1);
    chk_reg(4'd0, 8'hFF, "R6 wrap count byte0");
    chk_reg(4'd2, 8'hFF, "R6 wrap count byte2");
    chk_reg(4'd12, 8'h02, "R6 wrap flag only");
    chk_irq(1'b0, "R9 wrap not enabled");
    wr(4'd13, 8'h03);
    chk_irq(1'b1, "R9 wrap enabled");

    wr(4'd3, 8'hFE);
    chk_reg(4'd1, 8'hFF, "R7 bit0 clear has no effect");
    wr(4'd3, 8'h01);
    chk_reg(4'd0, 8'h00, "R7 count cleared byte0");
    chk_reg(4'd2, 8'h00, "R7 count cleared byte2");
    chk_reg(4'd12, 8'h02, "R7 clear does not set done");

    wr(4'd8, 8'h55);
    chk_reg(4'd8, 8'h01, "R10 spec addr write ignored");

    wr(4'd12, 8'h03);
    chk_reg(4'd12, 8'h00, "R8 both flags cleared");
    wr_ack(4'd12, 8'h02);
    chk_reg(4'd12, 8'h02, "R8 set wins over clear");
    chk_reg(4'd1, 8'hFF, "R6 wrap during clear");
    chk_reg(4'd4, 8'h03, "R5 addr after collided ack");

    wr_ack(4'd0, 8'h10);
    chk_reg(4'd0, 8'h10, "R11 written byte wins");
    chk_reg(4'd1, 8'hFF, "R11 other byte kept");
    chk_reg(4'd4, 8'h03, "R11 addr not advanced");
    chk_reg(4'd12, 8'h02, "R11 flags unchanged");

    ack(1);
    chk_reg(4'd0, 8'h0F, "R3 decrement after collision");
    chk_reg(4'd4, 8'h04, "R5 addr resumes");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule